// File: doc/BRIEF.md
# Nine-bit serial register port

This block is the configuration front end of a display bridge. A host talks to it over a three-wire serial link in which every word is nine bits: a type bit followed by one byte. A type bit of 0 makes the word a command holding an 8-bit register index. A type bit of 1 makes it a data byte. Registers are 16 bits wide. A write is one command followed by two data words, with the low byte sent first. One index, 0xBF, is special: after it is selected, each data byte becomes part of an outgoing packet payload. The payload leaves the block on a byte stream. The packet length is taken from the register at 0xBC.

To read a register back, the host first stores 0x00FA into the read-control register at 0xD4. It then sends the target index as a command, then a command word carrying 0xFA, and then clocks sixteen more bits while chip select stays low. During those bits the block drives the register value MSB first on a separate output, and an output-enable signal marks the time it drives. The serial pins are sampled in the system clock domain, so the system clock must run at least four times faster than SCK.

The payload stream uses valid/ready. A byte is offered with `pay_valid` and is taken on a clock edge where `pay_ready` is also high. While ready is low, the offered byte and its last flag stay unchanged. Incoming bytes are dropped if they arrive while the buffer is full. The bits of the configuration register at 0xB7 are brought out as plain control pins.

Top module: `spi9_regif`

## Requirements
- R1: A word is nine bits. It is sampled on rising SCK while chip select is low, MSB first. Bit 8 is the type: 0 means command (index), 1 means data.
- R2: A register write is a command with the index, then a data word with bits 7..0, then a data word with bits 15..8. The register changes only when the high-byte word completes.
- R3: Data words that arrive before any command has been received since reset are ignored.
- R4: Raising chip select in the middle of a word discards the partial word. The next complete word decodes normally.
- R5: Read sequence: write 0x00FA to index 0xD4, send a command with the target index, then send a command with 0xFA. The next 16 rising SCK edges shift the target register out on `spi_sdo`, MSB first, and `spi_sdo_oe` is high during those bits.
- R6: Indices outside the implemented window 0xB0..0xDF ignore writes and read as 0x0000.
- R7: After a command with 0xBF, the data bytes leave on the payload stream in arrival order. Only the first N bytes are kept, where N is the value at 0xBC. `pay_last` is set on byte N.
- R8: A packet keeps at most 16 bytes. Bytes beyond 16 are dropped, and `pay_last` then marks byte 16.
- R9: While `pay_valid` is high and `pay_ready` is low, `pay_data` and `pay_last` hold their values.
- R10: Register 0xB7 drives the control pins: bit 0 to `cfg_hs_en`, bit 3 to `cfg_video_en`, bit 6 to `cfg_dcs_sel`, bit 9 to `cfg_eot_en`.
- R11: After reset all registers read 0, the control pins are low, `pay_valid` is low and `spi_sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Read-back data to the host |
| spi_sdo_oe | output | 1 | High while `spi_sdo` is being driven |
| pay_valid | output | 1 | Payload byte offered |
| pay_ready | input | 1 | Sink accepts the payload byte |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final byte of the packet |
| cfg_hs_en | output | 1 | High-speed enable, from bit 0 of 0xB7 |
| cfg_video_en | output | 1 | Video enable, from bit 3 of 0xB7 |
| cfg_dcs_sel | output | 1 | Command-set select, from bit 6 of 0xB7 |
| cfg_eot_en | output | 1 | End-of-transmission enable, from bit 9 of 0xB7 |

## Verification
The bench builds the block with its default parameters. That gives a 48-register window from 0xB0 and a 16-byte payload buffer. With this window the configuration, packet-size and read-control indices are all implemented, while 0x20 and 0xE5 fall outside it, which exercises the zero read-back. The 16-byte depth lets a 20-byte packet reach the drop and end-marking case, and a short packet with the sink held off exercises back-pressure on the stream.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam logic [7:0]  IDX_CFG     = 8'hB7;
  localparam logic [7:0]  IDX_PKTLEN  = 8'hBC;
  localparam logic [7:0]  IDX_PAYLOAD = 8'hBF;
  localparam logic [7:0]  IDX_RDCTL   = 8'hD4;
  localparam logic [7:0]  RD_KEY      = 8'hFA;
  localparam logic [15:0] RD_ARM_VAL  = 16'h00FA;

  typedef struct packed {
    logic       is_data;
    logic [7:0] val;
  } frame_t;
endpackage

// File: rtl/spi9_rx.sv
module spi9_rx
  import spi9_pkg::*;
#(
  parameter int RD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            sdi,
  input  logic            rd_load,
  input  logic [RD_W-1:0] rd_word,
  output frame_t          frm,
  output logic            frm_vld,
  output logic            sdo,
  output logic            sdo_oe
);
  localparam int FW  = 9;
  localparam int CW  = $clog2(FW);
  localparam int RCW = $clog2(RD_W);

  logic [2:0]      sck_q;
  logic [1:0]      cs_q, sdi_q;
  logic [7:0]      sh;
  logic [CW-1:0]   bcnt;
  logic [RD_W-1:0] rsh;
  logic [RCW-1:0]  rcnt;
  logic            ract;
  logic            rise, cs_act, bit_in;

  assign rise   = sck_q[1] & ~sck_q[2];
  assign cs_act = ~cs_q[1];
  assign bit_in = sdi_q[1];
  assign sdo    = rsh[RD_W-1];
  assign sdo_oe = ract;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= '0;
      cs_q    <= '1;
      sdi_q   <= '0;
      sh      <= '0;
      bcnt    <= '0;
      rsh     <= '0;
      rcnt    <= '0;
      ract    <= 1'b0;
      frm     <= '0;
      frm_vld <= 1'b0;
    end else begin
      sck_q   <= {sck_q[1:0], sck};
      cs_q    <= {cs_q[0], cs_n};
      sdi_q   <= {sdi_q[0], sdi};
      frm_vld <= 1'b0;
      if (!cs_act) begin
        bcnt <= '0;
        ract <= 1'b0;
      end else if (rd_load) begin
        rsh  <= rd_word;
        rcnt <= '0;
        ract <= 1'b1;
      end else if (rise) begin
        if (ract) begin
          rsh  <= {rsh[RD_W-2:0], 1'b0};
          rcnt <= rcnt + 1'b1;
          if (rcnt == RCW'(RD_W-1)) ract <= 1'b0;
        end else if (bcnt == CW'(FW-1)) begin
          frm     <= {sh, bit_in};
          frm_vld <= 1'b1;
          bcnt    <= '0;
        end else begin
          sh   <= {sh[6:0], bit_in};
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  a_r4_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |=> !frm_vld);
  a_r5_load_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ract) |-> $past(rd_load));
endmodule

// File: rtl/spi9_regs.sv
module spi9_regs
  import spi9_pkg::*;
#(
  parameter logic [7:0] BASE = 8'hB0,
  parameter int         NUM  = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  widx,
  input  logic [15:0] wdat,
  input  logic [7:0]  ridx,
  output logic [15:0] rdat,
  output logic [3:0]  cfg_bits,
  output logic [15:0] pkt_len
);
  localparam int         AW      = $clog2(NUM);
  localparam logic [7:0] OFF_CFG = IDX_CFG - BASE;
  localparam logic [7:0] OFF_LEN = IDX_PKTLEN - BASE;

  logic [15:0] regs [NUM];
  logic [7:0]  roff, woff;

  function automatic logic in_win(input logic [7:0] i);
    return (i >= BASE) && (({1'b0, i} - {1'b0, BASE}) < 9'(NUM));
  endfunction

  assign roff = ridx - BASE;
  assign woff = widx - BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (we && in_win(widx)) begin
      regs[woff[AW-1:0]] <= wdat;
    end
  end

  assign rdat     = in_win(ridx) ? regs[roff[AW-1:0]] : 16'h0000;
  assign cfg_bits = {regs[OFF_CFG[AW-1:0]][9], regs[OFF_CFG[AW-1:0]][6],
                     regs[OFF_CFG[AW-1:0]][3], regs[OFF_CFG[AW-1:0]][0]};
  assign pkt_len  = regs[OFF_LEN[AW-1:0]];

  a_r10_cfg_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(cfg_bits));
endmodule

// File: rtl/spi9_payload.sv
module spi9_payload #(
  parameter int DEPTH = 16,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic [LW-1:0] len,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [8:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [LW-1:0] pkt_cnt, cap;
  logic          in_pkt, full, wr, rd;

  assign cap       = (len > LW'(DEPTH)) ? LW'(DEPTH) : len;
  assign in_pkt    = push && (pkt_cnt < cap);
  assign full      = (cnt == CW'(DEPTH));
  assign wr        = in_pkt && !full;
  assign out_valid = (cnt != '0);
  assign rd        = out_valid && out_ready;
  assign out_data  = mem[rp][7:0];
  assign out_last  = mem[rp][8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      pkt_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (start)       pkt_cnt <= '0;
      else if (in_pkt) pkt_cnt <= pkt_cnt + 1'b1;
      if (wr) begin
        mem[wp] <= {pkt_cnt == cap - LW'(1), din};
        wp      <= wp + 1'b1;
      end
      if (rd) rp <= rp + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(rd);
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: rtl/spi9_regif.sv
module spi9_regif
  import spi9_pkg::*;
#(
  parameter logic [7:0] BASE  = 8'hB0,
  parameter int         NUM   = 48,
  parameter int         DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_sdi,
  output logic       spi_sdo,
  output logic       spi_sdo_oe,
  output logic       pay_valid,
  input  logic       pay_ready,
  output logic [7:0] pay_data,
  output logic       pay_last,
  output logic       cfg_hs_en,
  output logic       cfg_video_en,
  output logic       cfg_dcs_sel,
  output logic       cfg_eot_en
);
  frame_t      frm;
  logic        frm_vld, is_cmd, is_dat, rd_load, sel_cmd, pay_push, pay_start, bank_we;
  logic        sel_vld, phase_hi, pay_mode, armed;
  logic [7:0]  sel_idx, lo_byte;
  logic [15:0] wdat, rdat, pkt_len;
  logic [3:0]  cfg_bits;

  assign is_cmd    = frm_vld && !frm.is_data;
  assign is_dat    = frm_vld && frm.is_data;
  assign rd_load   = is_cmd && armed && (frm.val == RD_KEY);
  assign sel_cmd   = is_cmd && !rd_load;
  assign pay_start = sel_cmd && (frm.val == IDX_PAYLOAD);
  assign pay_push  = is_dat && sel_vld && pay_mode;
  assign bank_we   = is_dat && sel_vld && !pay_mode && phase_hi;
  assign wdat      = {frm.val, lo_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld  <= 1'b0;
      sel_idx  <= '0;
      phase_hi <= 1'b0;
      pay_mode <= 1'b0;
      armed    <= 1'b0;
      lo_byte  <= '0;
    end else begin
      if (sel_cmd) begin
        sel_vld  <= 1'b1;
        sel_idx  <= frm.val;
        phase_hi <= 1'b0;
        pay_mode <= (frm.val == IDX_PAYLOAD);
      end
      if (rd_load) armed <= 1'b0;
      if (is_dat && sel_vld && !pay_mode) begin
        if (!phase_hi) begin
          lo_byte  <= frm.val;
          phase_hi <= 1'b1;
        end else begin
          phase_hi <= 1'b0;
        end
      end
      if (bank_we && sel_idx == IDX_RDCTL && wdat == RD_ARM_VAL) armed <= 1'b1;
    end
  end

  spi9_rx #(.RD_W(16)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .sdi(spi_sdi),
    .rd_load(rd_load), .rd_word(rdat), .frm(frm), .frm_vld(frm_vld),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );

  spi9_regs #(.BASE(BASE), .NUM(NUM)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .widx(sel_idx), .wdat(wdat),
    .ridx(sel_idx), .rdat(rdat), .cfg_bits(cfg_bits), .pkt_len(pkt_len)
  );

  spi9_payload #(.DEPTH(DEPTH), .LW(16)) u_pay (
    .clk(clk), .rst_n(rst_n), .start(pay_start), .push(pay_push), .din(frm.val),
    .len(pkt_len), .out_valid(pay_valid), .out_data(pay_data), .out_last(pay_last),
    .out_ready(pay_ready)
  );

  assign cfg_hs_en    = cfg_bits[0];
  assign cfg_video_en = cfg_bits[1];
  assign cfg_dcs_sel  = cfg_bits[2];
  assign cfg_eot_en   = cfg_bits[3];

  a_r2_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_hi) |-> $past(is_dat));
  a_r7_push_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pay_push |=> !$past(bank_we));
endmodule

// File: tb/spi9_regif_bench.sv
`timescale 1ns/100ps
module spi9_regif_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, pay_ready = 1'b1;
  logic sdo, sdo_oe, pay_valid, pay_last;
  logic [7:0] pay_data;
  logic hs, ven, dcs, eot;
  int total = 0, fails = 0;
  bit done = 0;
  logic [8:0] expq [$];

  always #2.5 clk = ~clk;

  spi9_regif u_spi9_regif (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_data(pay_data), .pay_last(pay_last), .cfg_hs_en(hs), .cfg_video_en(ven),
    .cfg_dcs_sel(dcs), .cfg_eot_en(eot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic t, input logic [7:0] v, input bit keep);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 8; i >= 0; i--) begin
      sdi = (i == 8) ? t : v[i];
      sck = 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    sck = 1'b0;
    if (!keep) begin
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [15:0] val);
    frame(1'b0, idx, 0);
    frame(1'b1, val[7:0], 0);
    frame(1'b1, val[15:8], 0);
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [15:0] val, output logic oe_ok);
    wr_reg(8'hD4, 16'h00FA);
    frame(1'b0, idx, 0);
    frame(1'b0, 8'hFA, 1);
    oe_ok = 1'b1;
    val = '0;
    for (int i = 0; i < 16; i++) begin
      sck = 1'b0;
      repeat (4) @(negedge clk);
      val = {val[14:0], sdo};
      if (!sdo_oe) oe_ok = 1'b0;
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    sck = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // Sends n payload bytes; expected bytes limited to min(len,16), last marks the final kept one
  task automatic send_pay(input int len, input int n, input logic [7:0] seed);
    int cap;
    cap = (len > 16) ? 16 : len;
    wr_reg(8'hBC, 16'(len));
    frame(1'b0, 8'hBF, 0);
    for (int i = 0; i < n; i++) begin
      if (i < cap) expq.push_back({(i == cap - 1), 8'(seed + i)});
      frame(1'b1, 8'(seed + i), 0);
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 2000 && expq.size() != 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    check({req, " all expected bytes seen"}, 32'(expq.size()), 0);
    check({req, " no extra bytes"}, {31'b0, pay_valid}, 0);
  endtask

  // Scoreboard monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && pay_valid && pay_ready) begin
      if (expq.size() == 0) check("R7 unexpected payload byte", {23'b0, pay_last, pay_data}, 32'h1FF);
      else check("R7 payload byte/last", {23'b0, pay_last, pay_data}, {23'b0, expq.pop_front()});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic oe;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11 cfg pins", {28'b0, eot, dcs, ven, hs}, 0);
    check("R11 pay_valid", {31'b0, pay_valid}, 0);
    check("R11 sdo_oe", {31'b0, sdo_oe}, 0);
    // R3 data before any command
    frame(1'b1, 8'h49, 0);
    frame(1'b1, 8'h02, 0);
    check("R3 orphan data no effect", {27'b0, pay_valid, eot, dcs, ven, hs}, 0);
    rd_reg(8'hB7, v, oe);
    check("R3/R11 cfg reg still zero", {16'b0, v}, 0);
    // R10 config pins
    wr_reg(8'hB7, 16'h0249);
    check("R10 all cfg pins set", {28'b0, eot, dcs, ven, hs}, 32'hF);
    wr_reg(8'hB7, 16'h0041);
    check("R10 hs and dcs only", {28'b0, eot, dcs, ven, hs}, 32'h5);
    // R2/R5 write then read, byte order
    wr_reg(8'hC0, 16'hA55A);
    rd_reg(8'hC0, v, oe);
    check("R2 low/high byte order", {16'b0, v}, 32'hA55A);
    check("R5 sdo_oe during readout", {31'b0, oe}, 1);
    check("R5 sdo_oe after readout", {31'b0, sdo_oe}, 0);
    rd_reg(8'hB7, v, oe);
    check("R5 read cfg reg", {16'b0, v}, 32'h0041);
    // R2 no commit without high byte
    frame(1'b0, 8'hC1, 0);
    frame(1'b1, 8'h77, 0);
    rd_reg(8'hC1, v, oe);
    check("R2 low byte alone does not commit", {16'b0, v}, 0);
    // R4 partial frame abort
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1; sck = 1'b0; repeat (4) @(negedge clk);
      sck = 1'b1; repeat (4) @(negedge clk);
    end
    sck = 1'b0; repeat (4) @(negedge clk);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    wr_reg(8'hC2, 16'h1234);
    rd_reg(8'hC2, v, oe);
    check("R4 frame after abort decodes", {16'b0, v}, 32'h1234);
    // R6 unimplemented indices
    wr_reg(8'h20, 16'hFFFF);
    rd_reg(8'h20, v, oe);
    check("R6 low unimplemented index", {16'b0, v}, 0);
    wr_reg(8'hE5, 16'hBEEF);
    rd_reg(8'hE5, v, oe);
    check("R6 high unimplemented index", {16'b0, v}, 0);
    // R1 data word distinguished by type bit: a command 0x5A selects, does not write
    frame(1'b0, 8'hC3, 0);
    frame(1'b0, 8'h5A, 0);
    frame(1'b0, 8'hC3, 0);
    frame(1'b1, 8'h01, 0);
    frame(1'b1, 8'h80, 0);
    rd_reg(8'hC3, v, oe);
    check("R1 type bit and MSB-first order", {16'b0, v}, 32'h8001);
    // R7 payload with length 5, extra bytes dropped
    send_pay(5, 7, 8'h30);
    drain("R7");
    // R8 overflow beyond 16
    send_pay(20, 20, 8'h80);
    drain("R8");
    // R9 back-pressure
    pay_ready = 1'b0;
    send_pay(3, 3, 8'hC0);
    check("R9 valid while held", {31'b0, pay_valid}, 1);
    check("R9 first byte offered", {24'b0, pay_data}, 32'hC0);
    repeat (30) @(negedge clk);
    check("R9 byte held stable", {23'b0, pay_valid, pay_data}, 32'h1C0);
    pay_ready = 1'b1;
    drain("R9");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule